// File: doc/BRIEF.md
# Triggered Memory-to-UART Byte DMA Channel

This block is one DMA channel that feeds a UART transmitter from memory, one byte at a time. Software sets a source address and a transfer count, then arms the channel. After that, every accepted trigger causes one memory read at the current address. The returned byte goes to the UART data port as a single-cycle write strobe, and the address steps forward by one.

A trigger comes from one of two places. It can be a software write to the control register. It can also be a hardware request that rises when the selected UART's transmit register becomes empty, and only while that UART's transmit interrupt enable is set. The count is programmed as the number of bytes minus one. When the last byte has gone out, the channel disarms itself, sets a sticky done flag and pulses an interrupt for one cycle. The channel can be attached to either of the UART ports. The control register accepts byte, half-word or word writes.

Register word offsets (`reg_addr`):
- 0: source address.
- 1: base count.
- 2: control.

Top module: `dmau_channel`

## Requirements
- R1: After reset, `mem_req`, `uart_wr` and `irq` are 0, and the source and control registers read 0.
- R2: With N-1 in the base count register (word 1), an armed channel moves exactly N bytes and then accepts no further trigger.
- R3: An accepted trigger raises `mem_req` on the next cycle, at the current source address. `mem_req` and `mem_addr` are held until `mem_ack` is sampled. On the cycle after that, `uart_wr` pulses for exactly one cycle with the returned byte on `uart_wdata`, and the address then increments by one.
- R4: While the arm bit (control bit 0) is 0, no trigger starts a transfer. This includes a write that sets the arm bit and the software trigger bit together.
- R5: With trigger select (control bit 1) at 0, writing 1 to control bit 2 starts one transfer when the channel is idle. Such a write is dropped while a transfer is in flight, and bit 2 always reads 0.
- R6: With trigger select at 1, a transfer starts once per rising edge of `uart_txe & uart_txie` of the selected port. A level held high starts only one transfer, and nothing starts while `uart_txie` is 0. A level already high when the channel is armed counts as a rising edge.
- R7: Register writes update only the byte lanes whose `reg_be` bit is 1. Lane 0 of the control register holds arm (bit 0), trigger select (bit 1), software trigger (bit 2) and done (bit 3, write 1 to clear). The port select field starts at bit 8 in lane 1.
- R8: Only the `uart_wr` bit of the port named by the port select field ever strobes. Only that port's empty and enable inputs act as a hardware trigger.
- R9: After the byte sent with the working count at zero, the arm bit reads 0 and the done bit reads 1. `irq` is high for exactly the one cycle after that byte's strobe.
- R10: Writing 0 to the arm bit during a transfer lets that byte complete. The channel then stops, with done left at 0 and no `irq`.
- R11: The working count and address are loaded only when the arm bit goes from 0 to 1. Rewriting 1 to an armed channel does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Byte-lane write strobes |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 8 | Memory read byte |
| uart_txe | input | NUM_UART | Per-port transmit register empty |
| uart_txie | input | NUM_UART | Per-port transmit interrupt enable |
| uart_wr | output | NUM_UART | Per-port transmit data write strobe |
| uart_wdata | output | 8 | Byte to transmit |
| irq | output | 1 | One-cycle transfer-complete pulse |

## Verification
A software trigger write takes effect at its clock edge, and `mem_req` is visible one cycle later. The strobe comes `lat + 1` cycles after that, where `lat` is the number of cycles the bench's memory model waits before acknowledging. `irq` follows the final strobe by exactly one cycle. Register contents can be read back on the cycle after the write edge. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the trigger to the strobe and compares that count, and the cycle gap between the last strobe and `irq`, against these figures. Checks that something is ignored wait well past the latest cycle a strobe could appear, then compare the strobe counts and read back the control register.

// File: rtl/dmau_pkg.sv
`timescale 1ns/1ps
package dmau_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } eng_state_t;

   // register word offsets
   localparam logic [1:0] OFS_SRC = 2'd0;
   localparam logic [1:0] OFS_CNT = 2'd1;
   localparam logic [1:0] OFS_CTL = 2'd2;

   // control register bit positions
   localparam int CTL_ARM  = 0;
   localparam int CTL_TSEL = 1;
   localparam int CTL_SWT  = 2;
   localparam int CTL_DONE = 3;
   localparam int CTL_PSEL = 8;

   // merge write data into an old value, one byte lane per strobe bit
   function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  be);
      logic [31:0] r;
      r = old_v;
      for (int b = 0; b < 4; b++) begin
         if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
      end
      return r;
   endfunction

endpackage

// File: rtl/dmau_regs.sv
`timescale 1ns/1ps
module dmau_regs
   import dmau_pkg::*;
#(
   parameter int AW    = 16,
   parameter int CW    = 16,
   parameter int SEL_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   input  logic [3:0]       reg_be,
   output logic [31:0]      reg_rdata,
   input  logic             done_set,
   output logic [AW-1:0]    src_q,
   output logic [CW-1:0]    cnt_q,
   output logic             arm_q,
   output logic             tsel_q,
   output logic [SEL_W-1:0] psel_q,
   output logic             arm_load,
   output logic             sw_go
);

   logic       wr_src, wr_cnt, wr_ctl, ctl_l0, ctl_l1;
   logic       done_q;
   logic [31:0] ctl_rd;

   assign wr_src = reg_wr && (reg_addr == OFS_SRC);
   assign wr_cnt = reg_wr && (reg_addr == OFS_CNT);
   assign wr_ctl = reg_wr && (reg_addr == OFS_CTL);
   assign ctl_l0 = wr_ctl && reg_be[0];
   assign ctl_l1 = wr_ctl && reg_be[1];

   assign arm_load = ctl_l0 && reg_wdata[CTL_ARM] && !arm_q;
   assign sw_go    = ctl_l0 && reg_wdata[CTL_SWT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         cnt_q  <= '0;
         arm_q  <= 1'b0;
         tsel_q <= 1'b0;
         psel_q <= '0;
         done_q <= 1'b0;
      end else begin
         if (wr_src) src_q <= AW'(lane_merge(32'(src_q), reg_wdata, reg_be));
         if (wr_cnt) cnt_q <= CW'(lane_merge(32'(cnt_q), reg_wdata, reg_be));
         if (ctl_l0) tsel_q <= reg_wdata[CTL_TSEL];
         if (ctl_l1) psel_q <= reg_wdata[CTL_PSEL +: SEL_W];
         if (done_set) begin
            arm_q  <= 1'b0;
            done_q <= 1'b1;
         end else if (ctl_l0) begin
            arm_q <= reg_wdata[CTL_ARM];
            if (reg_wdata[CTL_DONE]) done_q <= 1'b0;
         end
      end
   end

   always_comb begin
      ctl_rd                    = '0;
      ctl_rd[CTL_ARM]           = arm_q;
      ctl_rd[CTL_TSEL]          = tsel_q;
      ctl_rd[CTL_DONE]          = done_q;
      ctl_rd[CTL_PSEL +: SEL_W] = psel_q;
   end

   always_comb begin
      unique case (reg_addr)
         OFS_SRC: reg_rdata = 32'(src_q);
         OFS_CNT: reg_rdata = 32'(cnt_q);
         OFS_CTL: reg_rdata = ctl_rd;
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/dmau_trig.sv
`timescale 1ns/1ps
module dmau_trig #(
   parameter int NUM_UART  = 2,
   parameter int SEL_W     = 1,
   parameter bit EDGE_TRIG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                armed,
   input  logic                hw_mode,
   input  logic [SEL_W-1:0]    psel,
   input  logic [NUM_UART-1:0] uart_txe,
   input  logic [NUM_UART-1:0] uart_txie,
   input  logic                sw_go,
   input  logic                idle,
   output logic                go
);

   logic [NUM_UART-1:0] hit;
   logic                qual;
   logic                hw_fire;

   for (genvar i = 0; i < NUM_UART; i++) begin : g_port
      assign hit[i] = (psel == SEL_W'(i)) && uart_txe[i] && uart_txie[i];
   end

   assign qual = |hit;

   if (EDGE_TRIG) begin : g_edge
      logic prev_q;
      // history is held low while not listening, so a level already high counts on arming
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= (armed && hw_mode) ? qual : 1'b0;
      end
      assign hw_fire = qual && !prev_q;
   end else begin : g_level
      assign hw_fire = qual;
   end

   assign go = idle && armed && (hw_mode ? hw_fire : sw_go);

endmodule

// File: rtl/dmau_engine.sv
`timescale 1ns/1ps
module dmau_engine
   import dmau_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          armed,
   input  logic          arm_load,
   input  logic [CW-1:0] base_cnt,
   input  logic [AW-1:0] src_addr,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic [7:0]    mem_rdata,
   output logic          strobe,
   output logic [7:0]    wdata,
   output logic          last,
   output logic          idle,
   output logic          irq
);

   eng_state_t    state_q;
   logic [AW-1:0] addr_q;
   logic [CW-1:0] cnt_q;
   logic [7:0]    byte_q;
   logic          irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         cnt_q   <= '0;
         byte_q  <= '0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= last;
         unique case (state_q)
            ST_IDLE:  if (go) state_q <= ST_READ;
            ST_READ:  if (mem_ack) begin
                         byte_q  <= mem_rdata;
                         state_q <= ST_WRITE;
                      end
            ST_WRITE: begin
                         state_q <= ST_IDLE;
                         addr_q  <= addr_q + 1'b1;
                         if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                      end
            default:  state_q <= ST_IDLE;
         endcase
         if (arm_load) begin
            addr_q <= src_addr;
            cnt_q  <= base_cnt;
         end
      end
   end

   assign mem_req  = (state_q == ST_READ);
   assign mem_addr = addr_q;
   assign strobe   = (state_q == ST_WRITE);
   assign wdata    = byte_q;
   assign last     = strobe && armed && (cnt_q == '0);
   assign idle     = (state_q == ST_IDLE);
   assign irq      = irq_q;

endmodule

// File: rtl/dmau_channel.sv
`timescale 1ns/1ps
module dmau_channel #(
   parameter int AW        = 16,
   parameter int CW        = 16,
   parameter int NUM_UART  = 2,
   parameter bit EDGE_TRIG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [1:0]          reg_addr,
   input  logic [31:0]         reg_wdata,
   input  logic [3:0]          reg_be,
   output logic [31:0]         reg_rdata,
   output logic                mem_req,
   output logic [AW-1:0]       mem_addr,
   input  logic                mem_ack,
   input  logic [7:0]          mem_rdata,
   input  logic [NUM_UART-1:0] uart_txe,
   input  logic [NUM_UART-1:0] uart_txie,
   output logic [NUM_UART-1:0] uart_wr,
   output logic [7:0]          uart_wdata,
   output logic                irq
);

   localparam int SEL_W = (NUM_UART > 1) ? $clog2(NUM_UART) : 1;

   if (AW < 1 || AW > 32) begin : g_bad_aw
      $error("dmau_channel: AW must be 1..32");
   end
   if (CW < 1 || CW > 32) begin : g_bad_cw
      $error("dmau_channel: CW must be 1..32");
   end
   if (NUM_UART < 1 || SEL_W > 8) begin : g_bad_nu
      $error("dmau_channel: NUM_UART must be 1..256");
   end

   logic [AW-1:0]    src_q;
   logic [CW-1:0]    cnt_base;
   logic             arm_q, tsel_q;
   logic [SEL_W-1:0] psel_q;
   logic             arm_load, sw_go, go, idle, strobe, last;

   dmau_regs #(.AW(AW), .CW(CW), .SEL_W(SEL_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_be   (reg_be),
      .reg_rdata(reg_rdata),
      .done_set (last),
      .src_q    (src_q),
      .cnt_q    (cnt_base),
      .arm_q    (arm_q),
      .tsel_q   (tsel_q),
      .psel_q   (psel_q),
      .arm_load (arm_load),
      .sw_go    (sw_go)
   );

   dmau_trig #(.NUM_UART(NUM_UART), .SEL_W(SEL_W), .EDGE_TRIG(EDGE_TRIG)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    (arm_q),
      .hw_mode  (tsel_q),
      .psel     (psel_q),
      .uart_txe (uart_txe),
      .uart_txie(uart_txie),
      .sw_go    (sw_go),
      .idle     (idle),
      .go       (go)
   );

   dmau_engine #(.AW(AW), .CW(CW)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .armed    (arm_q),
      .arm_load (arm_load),
      .base_cnt (cnt_base),
      .src_addr (src_q),
      .mem_req  (mem_req),
      .mem_addr (mem_addr),
      .mem_ack  (mem_ack),
      .mem_rdata(mem_rdata),
      .strobe   (strobe),
      .wdata    (uart_wdata),
      .last     (last),
      .idle     (idle),
      .irq      (irq)
   );

   for (genvar i = 0; i < NUM_UART; i++) begin : g_wr
      assign uart_wr[i] = strobe && (psel_q == SEL_W'(i));
   end

endmodule

// File: rtl/dmau_channel_chk.sv
`timescale 1ns/1ps
module dmau_channel_chk #(
   parameter int AW       = 16,
   parameter int NUM_UART = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                mem_req,
   input logic                mem_ack,
   input logic [AW-1:0]       mem_addr,
   input logic [NUM_UART-1:0] uart_wr,
   input logic                irq,
   input logic                arm
);

   // R8: at most one port strobed
   p_one_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(uart_wr));

   // R3: strobe lasts one cycle
   p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|uart_wr) |=> !(|uart_wr));

   // R3: request and address held until acknowledged
   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R3: every strobe follows an acknowledged read
   p_wr_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|uart_wr) |-> $past(mem_req && mem_ack));

   // R4: a read only starts from an armed channel
   p_start_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(arm));

   // R9: interrupt follows a strobe and finds the channel disarmed
   p_irq_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(|uart_wr) && !arm));

   // R9: interrupt is a single-cycle pulse
   p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

endmodule

bind dmau_channel dmau_channel_chk #(.AW(AW), .NUM_UART(NUM_UART)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mem_req (mem_req),
   .mem_ack (mem_ack),
   .mem_addr(mem_addr),
   .uart_wr (uart_wr),
   .irq     (irq),
   .arm     (arm_q)
);

// File: tb/dmau_channel_tb.sv
`timescale 1ns/1ps
module dmau_channel_tb;

   localparam int AW = 16;
   localparam int NU = 2;
   localparam logic [1:0] A_SRC = 2'd0, A_CNT = 2'd1, A_CTL = 2'd2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [3:0]    reg_be = '0;
   logic [31:0]   reg_rdata;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic          mem_ack = 1'b0;
   logic [7:0]    mem_rdata = '0;
   logic [NU-1:0] uart_txe = '0;
   logic [NU-1:0] uart_txie = '0;
   logic [NU-1:0] uart_wr;
   logic [7:0]    uart_wdata;
   logic          irq;

   always #2.5 clk = ~clk;

   dmau_channel #(.AW(AW), .CW(16), .NUM_UART(NU)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .uart_txe(uart_txe), .uart_txie(uart_txie),
      .uart_wr(uart_wr), .uart_wdata(uart_wdata), .irq(irq)
   );

   int checks = 0, fails = 0;
   int cyc = 0, nstb = 0, np0 = 0, np1 = 0, nirq = 0;
   int last_stb_cyc = 0, irq_cyc = 0;
   int mem_lat = 0, mem_cnt = 0;
   logic [7:0] stb_log [0:255];

   function automatic logic [7:0] exp_byte(input logic [AW-1:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   // memory model and output monitor, all on the falling edge
   always @(negedge clk) begin
      cyc++;
      if (|uart_wr) begin
         stb_log[nstb % 256] = uart_wdata;
         if (uart_wr[0]) np0++;
         if (uart_wr[1]) np1++;
         nstb++;
         last_stb_cyc = cyc;
      end
      if (irq) begin
         nirq++;
         irq_cyc = cyc;
      end
      if (mem_ack) begin
         mem_ack <= 1'b0;
         mem_cnt = 0;
      end else if (mem_req) begin
         if (mem_cnt >= mem_lat) begin
            mem_ack   <= 1'b1;
            mem_rdata <= exp_byte(mem_addr);
            mem_cnt = 0;
         end else begin
            mem_cnt++;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
      @(negedge clk);
      reg_wr = 1'b0; reg_be = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic wait_stb(input int target);
      int k = 0;
      while (nstb < target && k < 200) begin
         @(negedge clk);
         k++;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 mem_req", mem_req, 0);
      chk("R1 uart_wr", uart_wr, 0);
      chk("R1 irq", irq, 0);
      rd(A_CTL, d); chk("R1 ctl", d, 0);
      rd(A_SRC, d); chk("R1 src", d, 0);
   endtask

   task automatic t_no_arm;
      logic [31:0] d;
      int base = nstb;
      wr(A_CTL, 32'h4, 4'b0001);
      repeat (8) @(negedge clk);
      chk("R4 swtrig unarmed", nstb - base, 0);
      chk("R4 no request", mem_req, 0);
      wr(A_CTL, 32'h5, 4'b0001);
      repeat (8) @(negedge clk);
      chk("R4 arm+trigger same write", nstb - base, 0);
      rd(A_CTL, d); chk("R4 armed after write", d, 32'h1);
      wr(A_CTL, 32'h0, 4'b0001);
   endtask

   task automatic t_sw_timing;
      logic [31:0] d;
      int base, irq0, k;
      mem_lat = 2;
      wr(A_SRC, 32'h1230, 4'hF);
      wr(A_CNT, 32'd2, 4'hF);
      wr(A_CTL, 32'h1, 4'b0001);
      base = nstb; irq0 = nirq;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = A_CTL; reg_wdata = 32'h5; reg_be = 4'b0001;
      @(negedge clk);
      reg_wr = 1'b0; reg_be = '0;
      chk("R3 req next cycle", mem_req, 1);
      chk("R3 req address", mem_addr, 32'h1230);
      k = 0;
      while (!(|uart_wr) && k < 20) begin
         @(negedge clk);
         k++;
      end
      chk("R3 strobe delay lat+1", k, 3);
      chk("R3 byte", uart_wdata, exp_byte(16'h1230));
      @(negedge clk);
      chk("R3 strobe one cycle", uart_wr, 0);
      chk("R3 address step", mem_addr, 32'h1231);
      wr(A_CTL, 32'h5, 4'b0001); wait_stb(base + 2);
      wr(A_CTL, 32'h5, 4'b0001); wait_stb(base + 3);
      repeat (3) @(negedge clk);
      chk("R2 three bytes for count 2", nstb - base, 3);
      chk("R3 byte 2", stb_log[(base + 1) % 256], exp_byte(16'h1231));
      chk("R3 byte 3", stb_log[(base + 2) % 256], exp_byte(16'h1232));
      chk("R9 one irq", nirq - irq0, 1);
      chk("R9 irq one cycle after strobe", irq_cyc - last_stb_cyc, 1);
      rd(A_CTL, d); chk("R9 disarmed and done", d, 32'h8);
      wr(A_CTL, 32'h4, 4'b0001);
      repeat (8) @(negedge clk);
      chk("R2 no fourth byte", nstb - base, 3);
      wr(A_CTL, 32'h8, 4'b0001);
      rd(A_CTL, d); chk("R7 done write-one-clear", d, 32'h0);
   endtask

   task automatic t_sw_busy;
      logic [31:0] d;
      int base;
      mem_lat = 4;
      wr(A_SRC, 32'h2000, 4'hF);
      wr(A_CNT, 32'd7, 4'hF);
      wr(A_CTL, 32'h1, 4'b0001);
      base = nstb;
      wr(A_CTL, 32'h5, 4'b0001);
      wr(A_CTL, 32'h5, 4'b0001);
      repeat (15) @(negedge clk);
      chk("R5 trigger while busy dropped", nstb - base, 1);
      rd(A_CTL, d); chk("R5 swtrig reads 0", d, 32'h1);
      wr(A_CTL, 32'h0, 4'b0001);
   endtask

   task automatic t_disarm;
      logic [31:0] d;
      int base, irq0;
      mem_lat = 5;
      wr(A_SRC, 32'h3000, 4'hF);
      wr(A_CNT, 32'd5, 4'hF);
      wr(A_CTL, 32'h1, 4'b0001);
      base = nstb; irq0 = nirq;
      wr(A_CTL, 32'h5, 4'b0001);
      wr(A_CTL, 32'h0, 4'b0001);
      repeat (15) @(negedge clk);
      chk("R10 in-flight byte completes", nstb - base, 1);
      chk("R10 byte value", stb_log[base % 256], exp_byte(16'h3000));
      chk("R10 no irq", nirq - irq0, 0);
      rd(A_CTL, d); chk("R10 done stays 0", d, 32'h0);
   endtask

   task automatic t_hw;
      logic [31:0] d;
      int base, irq0, p0;
      mem_lat = 1;
      wr(A_SRC, 32'h4000, 4'hF);
      wr(A_CNT, 32'd3, 4'hF);
      wr(A_CTL, 32'h102, 4'b0011);
      uart_txe[1] = 1'b1; uart_txie[1] = 1'b0;
      base = nstb; irq0 = nirq; p0 = np0;
      wr(A_CTL, 32'h103, 4'b0011);
      repeat (10) @(negedge clk);
      chk("R6 no trigger with enable 0", nstb - base, 0);
      uart_txie[1] = 1'b1;
      repeat (12) @(negedge clk);
      chk("R6 one byte on edge, level held", nstb - base, 1);
      for (int i = 0; i < 3; i++) begin
         uart_txe[0] = 1'b1; uart_txie[0] = 1'b1;
         repeat (2) @(negedge clk);
         uart_txe[0] = 1'b0;
         repeat (2) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      chk("R8 other port ignored", nstb - base, 1);
      for (int i = 0; i < 3; i++) begin
         uart_txe[1] = 1'b0;
         repeat (2) @(negedge clk);
         uart_txe[1] = 1'b1;
         repeat (8) @(negedge clk);
      end
      chk("R6 four edges four bytes", nstb - base, 4);
      chk("R8 no strobe on port 0", np0 - p0, 0);
      chk("R6 last byte", stb_log[(base + 3) % 256], exp_byte(16'h4003));
      chk("R9 hw irq", nirq - irq0, 1);
      rd(A_CTL, d); chk("R9 hw ctl after done", d, 32'h10A);
      uart_txe = '0; uart_txie = '0;
      wr(A_CTL, 32'h8, 4'b0001);
      rd(A_CTL, d); chk("R7 lane 0 only keeps port select", d, 32'h100);
      wr(A_CTL, 32'h1, 4'b0010);
      rd(A_CTL, d); chk("R7 lane 1 only leaves arm", d, 32'h0);
   endtask

   task automatic t_lanes;
      logic [31:0] d;
      int base;
      wr(A_SRC, 32'hAABB_1234, 4'hF);
      rd(A_SRC, d); chk("R7 src word", d, 32'h1234);
      wr(A_SRC, 32'h0000_5600, 4'b0010);
      rd(A_SRC, d); chk("R7 src upper lane", d, 32'h5634);
      wr(A_CNT, 32'h0000_0304, 4'hF);
      wr(A_CNT, 32'h0000_FF01, 4'b0001);
      rd(A_CNT, d); chk("R7 count lower lane", d, 32'h0301);
      mem_lat = 0;
      wr(A_SRC, 32'h5000, 4'hF);
      wr(A_CNT, 32'd4, 4'hF);
      wr(A_CTL, 32'h1, 4'b0001);
      base = nstb;
      wr(A_CTL, 32'h5, 4'b0001); wait_stb(base + 1);
      wr(A_CTL, 32'h1, 4'b0001);
      for (int i = 2; i <= 5; i++) begin
         wr(A_CTL, 32'h5, 4'b0001);
         wait_stb(base + i);
      end
      chk("R11 five bytes total", nstb - base, 5);
      chk("R11 fifth byte address", stb_log[(base + 4) % 256], exp_byte(16'h5004));
      rd(A_CTL, d); chk("R11 done after five", d, 32'h8);
      wr(A_CTL, 32'h8, 4'b0001);
   endtask

   initial begin
      #500000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_arm();
      t_sw_timing();
      t_sw_busy();
      t_disarm();
      t_hw();
      t_lanes();
      repeat (4) @(negedge clk);
      summary();
      $finish;
   end

endmodule